// File: doc/BRIEF.md
# Privilege-Qualified Hit Check and Data-Port Control Stage

This block closes the load/store pipeline. Each cycle it receives a request address tag, the stored tag of every way in the selected set, and two access-right bits per way: one that allows reads and one that allows writes. A way is taken to hold the line when its tag agrees and it carries at least one right. No separate valid bit is involved. From the matching way and its rights the block decides whether a load or a store has missed. It then asks the thread scheduler to park the thread that missed.

The same stage steers the data memory for the cache controller. A plain refill or update writes the whole line. A replacement writes the line and reads out the old contents in the same cycle. A second read port serves snoops. That port sees data being written in the same cycle, so the controller always receives the newest copy of the line. All results are registered once.

Top module: `lsu_priv_hit`

## Requirements
- R1: For a request accepted this cycle (`req_valid` high, `upd_valid` low), bit w of `hit_oh` is set when the tag of way w (bits w*TAG_W upward of `way_tags`) equals `req_tag` and `way_can_rd[w]` or `way_can_wr[w]` is 1. `hit` is the OR of `hit_oh`. With distinct way tags, at most one bit of `hit_oh` is set.
- R2: An accepted non-flush load (`req_store`=0) raises `miss` when no matching way has `way_can_rd` set.
- R3: An accepted non-flush store (`req_store`=1) raises `miss` when no matching way has `way_can_wr` set. This holds even when a way matches on read rights alone.
- R4: When `miss` is raised, `sleep_req` has exactly one bit set, at index `req_thread`. Otherwise `sleep_req` is all zero.
- R5: Update (`upd_valid`=1, `evict_valid`=0): `dmem_rd_en`=0, every bit of `dmem_wr_be` is 1, and `evict`=0.
- R6: Replacement (`upd_valid`=1, `evict_valid`=1): `dmem_rd_en`=1, every bit of `dmem_wr_be` is 1, and `evict`=1. With `upd_valid`=0, `dmem_rd_en`, `dmem_wr_be` and `evict` are all 0, whatever `evict_valid` is.
- R7: `flush` equals `req_flush` of an accepted request. A flush request never raises `miss` or `sleep_req`.
- R8: When `snp_valid` is 1, `snp_data` returns `upd_data` if `upd_valid` is 1 and `snp_index` equals `upd_index` (write-first). Otherwise it returns `snp_mem_data`. When `snp_valid` is 0, `snp_data` is zero.
- R9: While `upd_valid` is 1, the request inputs are ignored. `hit_oh`, `hit`, `miss`, `sleep_req` and `flush` are all 0.
- R10: Every output is registered and appears on the cycle after its inputs. An active-low `rst_n` clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_tag | input | TAG_W | Address tag of the request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_flush | input | 1 | Request is a flush |
| req_thread | input | TID_W | Thread that issued the request |
| way_tags | input | WAYS*TAG_W | Stored tag per way, way 0 in the low bits |
| way_can_rd | input | WAYS | Read right per way |
| way_can_wr | input | WAYS | Write right per way |
| upd_valid | input | 1 | Cache controller writes a line |
| evict_valid | input | 1 | The write also evicts the old line |
| upd_index | input | IDX_W | Line index of the controller write |
| upd_data | input | LINE_BYTES*8 | Line being written |
| snp_valid | input | 1 | Snoop read present |
| snp_index | input | IDX_W | Line index of the snoop |
| snp_mem_data | input | LINE_BYTES*8 | Snoop port data from the memory |
| hit_oh | output | WAYS | One-hot matching way |
| hit | output | 1 | Any way matched |
| miss | output | 1 | Load or store miss |
| evict | output | 1 | Replacement occurred |
| flush | output | 1 | Flush passed through |
| sleep_req | output | THREADS | Park request for the missing thread |
| dmem_rd_en | output | 1 | Data memory read enable |
| dmem_wr_be | output | LINE_BYTES | Data memory byte write enables |
| snp_data | output | LINE_BYTES*8 | Write-first snoop data |

## Verification
Every result leaves a single register, so each result is due exactly one clock edge after its inputs. This applies to the hit vector, the miss and sleep mask, the data enables, evict, flush and the snoop data. The bench drives each vector on a falling edge. It waits for the next rising edge and samples one time unit later. That way it compares each output on the cycle it becomes valid, before the next vector can disturb it. Reset is checked by sampling after a registered edge with reset held low.

// File: rtl/lsu_priv_hit.sv
module lsu_priv_hit #(
  parameter int WAYS       = 4,
  parameter int TAG_W      = 4,
  parameter int THREADS    = 4,
  parameter int LINE_BYTES = 8,
  parameter int IDX_W      = 4,
  localparam int TID_W     = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [TAG_W-1:0]        req_tag,
  input  logic                    req_store,
  input  logic                    req_flush,
  input  logic [TID_W-1:0]        req_thread,
  input  logic [WAYS*TAG_W-1:0]   way_tags,
  input  logic [WAYS-1:0]         way_can_rd,
  input  logic [WAYS-1:0]         way_can_wr,
  input  logic                    upd_valid,
  input  logic                    evict_valid,
  input  logic [IDX_W-1:0]        upd_index,
  input  logic [LINE_W-1:0]       upd_data,
  input  logic                    snp_valid,
  input  logic [IDX_W-1:0]        snp_index,
  input  logic [LINE_W-1:0]       snp_mem_data,
  output logic [WAYS-1:0]         hit_oh,
  output logic                    hit,
  output logic                    miss,
  output logic                    evict,
  output logic                    flush,
  output logic [THREADS-1:0]      sleep_req,
  output logic                    dmem_rd_en,
  output logic [LINE_BYTES-1:0]   dmem_wr_be,
  output logic [LINE_W-1:0]       snp_data
);

  logic              take_req, is_access, ld_miss, st_miss, any_miss;
  logic              is_repl, is_upd;
  logic [WAYS-1:0]   match;
  logic [THREADS-1:0] sleep_nx;
  logic [LINE_W-1:0] snp_nx;

  assign take_req = req_valid & ~upd_valid;
  assign is_access = take_req & ~req_flush;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w] = take_req
                    && (way_tags[w*TAG_W +: TAG_W] == req_tag)
                    && (way_can_rd[w] || way_can_wr[w]);
  end

  assign ld_miss  = is_access & ~req_store & ~|(match & way_can_rd);
  assign st_miss  = is_access &  req_store & ~|(match & way_can_wr);
  assign any_miss = ld_miss | st_miss;

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    assign sleep_nx[t] = any_miss && (req_thread == TID_W'(t));
  end

  assign is_repl = upd_valid &  evict_valid;
  assign is_upd  = upd_valid & ~evict_valid;

  assign snp_nx = !snp_valid ? '0 :
                  (upd_valid && snp_index == upd_index) ? upd_data : snp_mem_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_oh     <= '0;
      hit        <= 1'b0;
      miss       <= 1'b0;
      evict      <= 1'b0;
      flush      <= 1'b0;
      sleep_req  <= '0;
      dmem_rd_en <= 1'b0;
      dmem_wr_be <= '0;
      snp_data   <= '0;
    end else begin
      hit_oh     <= match;
      hit        <= |match;
      miss       <= any_miss;
      evict      <= is_repl;
      flush      <= take_req & req_flush;
      sleep_req  <= sleep_nx;
      dmem_rd_en <= is_repl;
      dmem_wr_be <= {LINE_BYTES{is_upd | is_repl}};
      snp_data   <= snp_nx;
    end
  end

endmodule

// File: rtl/lsu_priv_hit_chk.sv
module lsu_priv_hit_chk #(
  parameter int WAYS       = 4,
  parameter int THREADS    = 4,
  parameter int LINE_BYTES = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [WAYS-1:0]       hit_oh,
  input logic                  miss,
  input logic                  flush,
  input logic                  evict,
  input logic [THREADS-1:0]    sleep_req,
  input logic                  dmem_rd_en,
  input logic [LINE_BYTES-1:0] dmem_wr_be
);

  assert_single_way_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit_oh) <= 1);

  assert_sleep_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> $countones(sleep_req) == 1);

  assert_sleep_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !miss |-> sleep_req == '0);

  assert_full_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dmem_wr_be != '0) |-> (&dmem_wr_be));

  assert_repl_ports_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evict |-> (dmem_rd_en && (&dmem_wr_be)));

  assert_read_only_repl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_rd_en |-> evict);

  assert_flush_no_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !miss);

endmodule

bind lsu_priv_hit lsu_priv_hit_chk #(
  .WAYS(WAYS), .THREADS(THREADS), .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hit_oh(hit_oh), .miss(miss), .flush(flush),
  .evict(evict), .sleep_req(sleep_req), .dmem_rd_en(dmem_rd_en),
  .dmem_wr_be(dmem_wr_be)
);

// File: tb/test_lsu_priv_hit.sv
`timescale 1ns/1ps
module test_lsu_priv_hit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_store = 0, req_flush = 0;
  logic [3:0]  req_tag = 0;
  logic [1:0]  req_thread = 0;
  logic [15:0] way_tags = {4'd13, 4'd9, 4'd5, 4'd1};
  logic [3:0]  way_can_rd = 0, way_can_wr = 0;
  logic        upd_valid = 0, evict_valid = 0, snp_valid = 0;
  logic [3:0]  upd_index = 0, snp_index = 0;
  logic [63:0] upd_data = 0, snp_mem_data = 0;
  logic [3:0]  hit_oh;
  logic        hit, miss, evict, flush, dmem_rd_en;
  logic [3:0]  sleep_req;
  logic [7:0]  dmem_wr_be;
  logic [63:0] snp_data;

  int vectors = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lsu_priv_hit i_lsu_priv_hit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
    .req_store(req_store), .req_flush(req_flush), .req_thread(req_thread),
    .way_tags(way_tags), .way_can_rd(way_can_rd), .way_can_wr(way_can_wr),
    .upd_valid(upd_valid), .evict_valid(evict_valid), .upd_index(upd_index),
    .upd_data(upd_data), .snp_valid(snp_valid), .snp_index(snp_index),
    .snp_mem_data(snp_mem_data), .hit_oh(hit_oh), .hit(hit), .miss(miss),
    .evict(evict), .flush(flush), .sleep_req(sleep_req),
    .dmem_rd_en(dmem_rd_en), .dmem_wr_be(dmem_wr_be), .snp_data(snp_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [3:0] tg, input logic st,
                       input logic fl, input logic [1:0] th,
                       input logic [3:0] rd, input logic [3:0] wr,
                       input logic up, input logic ev, input logic sv,
                       input logic [3:0] si, input logic [3:0] ui,
                       input logic [63:0] ud, input logic [63:0] md);
    logic take, acc, rdh, wrh, em_miss;
    logic [3:0] em, esl;
    logic [63:0] esnp;
    @(negedge clk);
    req_valid = v; req_tag = tg; req_store = st; req_flush = fl; req_thread = th;
    way_can_rd = rd; way_can_wr = wr; upd_valid = up; evict_valid = ev;
    snp_valid = sv; snp_index = si; upd_index = ui; upd_data = ud; snp_mem_data = md;
    take = v & ~up;
    em = '0;
    for (int w = 0; w < 4; w++)
      if (take && (4*w + 1) == int'(tg) && (rd[w] || wr[w])) em[w] = 1'b1;
    rdh = |(em & rd);
    wrh = |(em & wr);
    acc = take & ~fl;
    em_miss = acc & (st ? ~wrh : ~rdh);
    esl = em_miss ? (4'b1 << th) : 4'b0;
    esnp = !sv ? 64'd0 : ((up && si == ui) ? ud : md);
    @(posedge clk); #1;
    if (up) begin
      chk("R9 hit_oh ignored", 64'(hit_oh), 0);
      chk("R9 miss ignored", 64'(miss), 0);
      chk("R9 flush ignored", 64'(flush), 0);
    end else begin
      chk("R1 hit_oh", 64'(hit_oh), 64'(em));
      chk("R1 hit", 64'(hit), 64'(|em));
      chk(st ? "R3 store miss" : "R2 load miss", 64'(miss), 64'(em_miss));
      chk("R7 flush", 64'(flush), 64'(take & fl));
    end
    chk("R4 sleep", 64'(sleep_req), 64'(esl));
    chk(ev ? "R6 rd_en" : "R5 rd_en", 64'(dmem_rd_en), 64'(up & ev));
    chk(ev ? "R6 wr_be" : "R5 wr_be", 64'(dmem_wr_be), up ? 64'hFF : 64'h0);
    chk(ev ? "R6 evict" : "R5 evict", 64'(evict), 64'(up & ev));
    chk("R8 snoop", snp_data, esnp);
  endtask

  task automatic check_reset();
    chk("R10 reset hit_oh", 64'(hit_oh), 0);
    chk("R10 reset miss", 64'(miss), 0);
    chk("R10 reset sleep", 64'(sleep_req), 0);
    chk("R10 reset wr_be", 64'(dmem_wr_be), 0);
    chk("R10 reset rd_en", 64'(dmem_rd_en), 0);
    chk("R10 reset evict", 64'(evict), 0);
    chk("R10 reset flush", 64'(flush), 0);
    chk("R10 reset snoop", snp_data, 0);
  endtask

  initial begin
    req_valid = 1; req_tag = 4'd1; way_can_rd = 4'hF; upd_valid = 1; evict_valid = 1;
    snp_valid = 1; snp_mem_data = 64'hDEAD;
    repeat (3) @(posedge clk);
    #1 check_reset();
    @(negedge clk); rst_n = 1;

    // R1 R2 R3 R4: sweep tags, privileges and access type
    for (int tg = 0; tg < 16; tg++)
      for (int p = 0; p < 256; p++)
        for (int st = 0; st < 2; st++)
          apply(1'b1, 4'(tg), st[0], 1'b0, 2'(tg + p + st), p[3:0], p[7:4],
                1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 64'd0, 64'd0);

    // R7: flush with hitting and missing tags
    for (int tg = 0; tg < 16; tg++)
      apply(1'b1, 4'(tg), tg[0], 1'b1, 2'(tg), 4'h0, 4'h0,
            1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 64'd0, 64'd0);

    // R5 R6 R8 R9: controller writes, evict without update, snoop forwarding
    for (int c = 0; c < 64; c++)
      apply(c[0], 4'd5, c[1], 1'b0, 2'(c), 4'h3, 4'h1, c[2], c[3], c[4],
            4'(c[5] ? 7 : 3), 4'd7, 64'h1111_2222_3333_0000 + 64'(c),
            64'hAAAA_BBBB_CCCC_0000 + 64'(c));

    // R10: reset in mid-run clears outputs
    apply(1'b1, 4'd2, 1'b0, 1'b0, 2'd3, 4'h0, 4'h0,
          1'b1, 1'b1, 1'b1, 4'd1, 4'd1, 64'h55, 64'h66);
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1 check_reset();
    @(negedge clk); rst_n = 1;

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule